// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands, each `WIDTH` bits wide (8 by default), and returns a product twice as wide. It uses one adder that is `WIDTH` bits wide and repeats a test, add and shift sequence once per multiplier bit. A small Moore controller runs the sequence and sets the register controls of a datapath. The datapath holds a carry flip-flop, an accumulator (the upper product half), a multiplier register (the lower product half) and a multiplicand register.

A caller waits until `done` is high, then presents the operands and pulses `start` for one clock. `done` drops while the block works. When `done` rises again, `product` holds the result. The number of cycles a multiplication takes depends on how many bits of the multiplier are 1, because each such bit adds one add cycle. The result stays on `product` until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: `done` becomes 1, `product` becomes 0 and the iteration count becomes 0.
- R2: When `start` is 1 at a rising edge while idle, the controller leaves idle and `done` is 0 in the following cycle.
- R3: In the cycle after the start is accepted, an initialize step clears the carry and the accumulator and loads the multiplicand and multiplier registers from the ports. After that step, `product` reads {all zeros, multiplier}.
- R4: A test step goes to the add step when the count is below `WIDTH` and the multiplier register's bit 0 is 1. It goes to the shift step when the count is below `WIDTH` and that bit is 0. When the count equals `WIDTH`, it returns to idle.
- R5: The add step writes the `WIDTH`-bit sum of the accumulator and the multiplicand into the accumulator and the adder's carry-out into the carry flip-flop. The next step is always the shift step.
- R6: The shift step moves {carry, accumulator, multiplier register} right by one bit, with 0 entering the carry. It adds one to the count, and the next step is test.
- R7: When `done` rises again, `product` equals multiplicand times multiplier. The upper half comes from the accumulator and the lower half from the multiplier register.
- R8: The cycles from the edge that accepts `start` to the edge that makes `done` high again number 2 + 2*`WIDTH` + (the count of 1 bits in the multiplier).
- R9: `done` is 1 exactly while idle. While idle with `start` at 0, `product` does not change, even when the operand inputs change.
- R10: A `start` pulse, or a change of operands, while `done` is 0 has no effect on the result or on the latency of the multiplication in progress.
- R11: The register controls depend only on the controller state, and at most one of load, add and shift is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiplication |
| multiplicand | input | WIDTH | Unsigned multiplicand, sampled in the initialize step |
| multiplier | input | WIDTH | Unsigned multiplier, sampled in the initialize step |
| product | output | 2*WIDTH | {accumulator, multiplier register}; holds the result once done |
| done | output | 1 | High while idle |

## Verification
The bench first runs directed operands. Zero and one, in both operand positions, expose a faulty initial clear or a faulty bit path. All-ones operands give the longest add chain and the largest carry out of the adder, so they expose a dropped carry or a shift that does not clear the carry. Seeded random pairs then cover mixed bit patterns. For every run the bench compares the measured latency with the popcount formula, which separates an add-or-shift decision taken on the wrong bit from a decision taken correctly. It also pokes `start` and changes the operands in the middle of a run, changes the operands while idle, and asserts reset during a run.

// File: rtl/shift_add_mul_pkg.sv
// Package: types shared by the shift-add multiplier controller and datapath.
// Assumes: the controller state is encoded in three bits.
package shift_add_mul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INIT  = 3'd1,
        ST_TEST  = 3'd2,
        ST_ADD   = 3'd3,
        ST_SHIFT = 3'd4
    } mul_state_e;

    // Register controls that the controller drives, decoded from the state only
    typedef struct packed {
        logic ld_mq;   // clear carry/accumulator, load multiplicand and multiplier
        logic ld_ac;   // write adder sum and carry-out
        logic sh;      // shift {carry, accumulator, multiplier reg} right
    } mul_ctl_t;

endpackage

// File: rtl/shift_add_mul_adder.sv
// Module: shift_add_mul_adder
// Unsigned adder WIDTH bits wide that returns the sum and the carry-out.
// Assumes: both operands are unsigned; purely combinational.
module shift_add_mul_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int SW = WIDTH + 1;

    logic [SW-1:0] wide_sum;

    // Purpose: add one bit wider than the operands to capture the carry
    always_comb begin
        wide_sum  = SW'(op_a) + SW'(op_b);
        sum       = wide_sum[WIDTH-1:0];
        carry_out = wide_sum[WIDTH];
    end
endmodule

// File: rtl/shift_add_mul_ctrl.sv
// Module: shift_add_mul_ctrl
// Moore controller for the shift-add multiplier. It moves through idle,
// initialize, test, add and shift, and counts the completed shift steps.
// Assumes: q_lsb is bit 0 of the datapath's multiplier register; reset is
// synchronous and active low.
module shift_add_mul_ctrl
    import shift_add_mul_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            q_lsb,
    output mul_state_e      state,
    output logic [CW-1:0]   iter_cnt,
    output mul_ctl_t        ctl
);
    localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH);

    mul_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Purpose: next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_INIT;
            ST_INIT: begin
                state_d = ST_TEST;
                cnt_d   = '0;
            end
            ST_TEST: begin
                if (cnt_q < LAST_CNT) state_d = q_lsb ? ST_ADD : ST_SHIFT;
                else                  state_d = ST_IDLE;
            end
            ST_ADD:   state_d = ST_SHIFT;
            ST_SHIFT: begin
                state_d = ST_TEST;
                cnt_d   = cnt_q + CW'(1);
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Purpose: state and count registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Purpose: Moore decode of the register controls from the state alone
    always_comb begin
        ctl       = '0;
        ctl.ld_mq = (state_q == ST_INIT);
        ctl.ld_ac = (state_q == ST_ADD);
        ctl.sh    = (state_q == ST_SHIFT);
    end

    assign state    = state_q;
    assign iter_cnt = cnt_q;
endmodule

// File: rtl/shift_add_mul_dp.sv
// Module: shift_add_mul_dp
// Datapath: carry flip-flop, accumulator, multiplier register and
// multiplicand register around one adder.
// Assumes: at most one control in ctl is active per cycle.
module shift_add_mul_dp
    import shift_add_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mul_ctl_t           ctl,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic               q_lsb,
    output logic [2*WIDTH-1:0] prod
);
    logic             c_q;
    logic [WIDTH-1:0] acc_q, mq_q, mcand_q;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;

    shift_add_mul_adder #(.WIDTH(WIDTH)) u_adder (
        .op_a      (acc_q),
        .op_b      (mcand_q),
        .sum       (add_sum),
        .carry_out (add_cout)
    );

    // Purpose: load, add or shift the datapath registers per the controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= 1'b0;
            acc_q   <= '0;
            mq_q    <= '0;
            mcand_q <= '0;
        end else if (ctl.ld_mq) begin
            c_q     <= 1'b0;
            acc_q   <= '0;
            mq_q    <= mplier_in;
            mcand_q <= mcand_in;
        end else if (ctl.ld_ac) begin
            c_q     <= add_cout;
            acc_q   <= add_sum;
        end else if (ctl.sh) begin
            c_q     <= 1'b0;
            acc_q   <= {c_q, acc_q[WIDTH-1:1]};
            mq_q    <= {acc_q[0], mq_q[WIDTH-1:1]};
        end
    end

    assign q_lsb = mq_q[0];
    assign prod  = {acc_q, mq_q};
endmodule

// File: rtl/shift_add_mul.sv
// Module: shift_add_mul (top)
// Unsigned shift-add multiplier: WIDTH x WIDTH operands, 2*WIDTH product.
// Assumes: start is a synchronous pulse; a start is accepted only while
// done is high.
module shift_add_mul
    import shift_add_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);
    localparam int CW = $clog2(WIDTH + 1);

    mul_state_e    fsm_state;
    logic [CW-1:0] iter_cnt;
    mul_ctl_t      ctl;
    logic          q_lsb;

    shift_add_mul_ctrl #(.WIDTH(WIDTH), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .q_lsb    (q_lsb),
        .state    (fsm_state),
        .iter_cnt (iter_cnt),
        .ctl      (ctl)
    );

    shift_add_mul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .q_lsb     (q_lsb),
        .prod      (product)
    );

    // Purpose: done follows the idle state
    assign done = (fsm_state == ST_IDLE);
endmodule

// File: rtl/shift_add_mul_chk.sv
// Module: shift_add_mul_chk
// Property checker bound into shift_add_mul; observes ports and the
// controller's state, count and controls.
// Assumes: rst_n is held low from time zero until the first edges pass.
module shift_add_mul_chk
    import shift_add_mul_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   multiplier,
    input logic [2*WIDTH-1:0] product,
    input logic               done,
    input mul_state_e         fsm_state,
    input logic [CW-1:0]      iter_cnt,
    input mul_ctl_t           ctl
);
    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    p_init_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_mq |=> (product == {{WIDTH{1'b0}}, $past(multiplier)}));

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cnt <= CW'(WIDTH));

    p_add_to_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_ac |=> ctl.sh);

    p_shift_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sh |=> (fsm_state == ST_TEST && iter_cnt == $past(iter_cnt) + CW'(1)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && fsm_state != ST_TEST) |=> !done);

    p_one_ctl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.ld_mq, ctl.ld_ac, ctl.sh}));
endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .multiplier (multiplier),
    .product    (product),
    .done       (done),
    .fsm_state  (fsm_state),
    .iter_cnt   (iter_cnt),
    .ctl        (ctl)
);

// File: tb/shift_add_mul_bench.sv
// Bench for shift_add_mul: directed corner operands plus seeded random pairs.
module shift_add_mul_bench;
    localparam int WIDTH   = 8;
    localparam int CLK_PER = 10;
    localparam int RUN_MAX = 200;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [WIDTH-1:0]   multiplicand = '0;
    logic [WIDTH-1:0]   multiplier = '0;
    logic [2*WIDTH-1:0] product;
    logic               done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    shift_add_mul #(.WIDTH(WIDTH)) u_shift_add_mul (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .product      (product),
        .done         (done)
    );

    function automatic int ones(input logic [WIDTH-1:0] v);
        int n = 0;
        for (int i = 0; i < WIDTH; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [2*WIDTH-1:0] ref_mul(input logic [WIDTH-1:0] a,
                                                   input logic [WIDTH-1:0] b);
        return (2*WIDTH)'(a) * (2*WIDTH)'(b);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One multiplication; optionally pokes start and operands mid-run (R10)
    task automatic run_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input bit poke);
        int cyc = 0;
        int exp_lat = 2 + 2*WIDTH + ones(b);
        @(negedge clk);
        multiplicand = a;
        multiplier   = b;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        check(done == 1'b0, "R2 done after start", done, 0);
        while (!done && cyc < RUN_MAX) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2)
                check(product == {{WIDTH{1'b0}}, b}, "R3 init load", product, {{WIDTH{1'b0}}, b});
            if (poke && cyc == 5) begin
                start        = 1'b1;
                multiplicand = ~a;
                multiplier   = ~b;
            end
            if (poke && cyc == 6) start = 1'b0;
        end
        check(cyc < RUN_MAX, "R4 run finished", cyc, exp_lat);
        check(product == ref_mul(a, b), poke ? "R10 R7 product" : "R7 R5 R6 product",
              product, ref_mul(a, b));
        check(cyc - 1 == exp_lat, poke ? "R10 R8 latency" : "R8 R4 R11 latency",
              cyc - 1, exp_lat);
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*WIDTH-1:0] held;
        void'($urandom(32'd20240607));
        start = 1'b1;                       // start during reset must be ignored
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R1 reset done", done, 1);
        check(product == '0, "R1 reset product", product, 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b1, "R9 idle done", done, 1);

        run_mul(8'd0,   8'd0,   1'b0);
        run_mul(8'd1,   8'd0,   1'b0);
        run_mul(8'd0,   8'd255, 1'b0);
        run_mul(8'd1,   8'd1,   1'b0);
        run_mul(8'd255, 8'd1,   1'b0);
        run_mul(8'd1,   8'd255, 1'b0);
        run_mul(8'd255, 8'd255, 1'b0);
        run_mul(8'd170, 8'd85,  1'b0);

        // R9: product holds while idle despite operand changes
        held = product;
        multiplicand = 8'd3;
        multiplier   = 8'd7;
        repeat (4) @(negedge clk);
        check(product == held, "R9 hold product", product, held);
        check(done == 1'b1, "R9 hold done", done, 1);

        // R10: busy start and operand change ignored
        run_mul(8'd200, 8'd99, 1'b1);
        run_mul(8'd255, 8'd255, 1'b1);

        for (int i = 0; i < 40; i++)
            run_mul(WIDTH'($urandom), WIDTH'($urandom), (i % 5) == 0);

        // R1: reset in mid-run returns to idle with zero product
        @(negedge clk);
        multiplicand = 8'd77;
        multiplier   = 8'd91;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b1, "R1 mid-run reset done", done, 1);
        check(product == '0, "R1 mid-run reset product", product, 0);
        rst_n = 1'b1;
        run_mul(8'd77, 8'd91, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule